// File: doc/BRIEF.md
# Switching-Edge Fault Capture and Status Word Builder

This block records the health of a set of PWM-driven low-side output channels. Each channel has two pulse inputs from the PWM generator: one marks the cycle where the channel turns on, and one marks the cycle where it turns off. On a turn-on pulse, the block stores that channel's flyback-comparator level. On a turn-off pulse, it stores that channel's off-state comparator level and its current-limit comparator level. Each stored value stays in place until the next pulse of the same kind on the same channel. All comparator, thermal and reset-pin levels arrive already synchronised to `clk`.

A host serial link reads the status through a snapshot. When a frame begins (`frame_start`), the block packs the stored flags, the live reset-pin levels and the live thermal flag into one fixed-layout word. That word is offered on a valid/ready output. Because the offered word is a frozen copy, the stored flags can keep changing during a transfer without affecting the word being shifted out.

Back-pressure rules:
- While `snap_valid` is high and `snap_ready` is low, the word holds still.
- A `frame_start` in that state is ignored.
- When `snap_ready` and `frame_start` are both high in the same cycle, the current word is consumed and a fresh one takes its place.
- `snap_ready` with no `frame_start` drops `snap_valid` on the next cycle.

Top module: `edge_diag_capture`

## Requirements
- R1: On a cycle where `rise_stb[c]` is 1, the turn-on flag of channel c takes the value of `fly_cmp[c]` (1 = output below flyback threshold).
- R2: On a cycle where `fall_stb[c]` is 1, the turn-off flag of channel c takes the value of `off_cmp[c]` (1 = output above off-state threshold).
- R3: On a cycle where `fall_stb[c]` is 1, the current flag of channel c takes the value of `cur_ok[c]` (1 = below limit, 0 = overcurrent).
- R4: Word bit 2c holds the turn-on flag of channel c and bit 2c+1 holds its turn-off flag. Channel 0 is the first channel, so with four channels bits 0 to 7 are interleaved.
- R5: With four channels, bit 8 is `rst_pin_a`, bit 9 is `rst_pin_b` and bit 10 is `therm_ok` (0 = overtemperature). Bits 11 to 14 are the current flags of channels 0 to 3. All of these are sampled in the frame-start cycle.
- R6: The top bit of every offered word is 1.
- R7: An accepted `frame_start` raises `snap_valid` on the next cycle. The word then reflects the flags stored before that edge. Strobes arriving afterwards do not change the offered word.
- R8: While `snap_valid` is 1 and `snap_ready` is 0, the word and `snap_valid` hold, and any `frame_start` is ignored. `snap_ready` together with `frame_start` loads a new word. `snap_ready` alone clears `snap_valid`.
- R9: Reset (`rst_n` = 0) clears `snap_valid`, clears the turn-on and turn-off flags to 0, and sets the current flags to 1.
- R10: A flag changes only on its own channel's matching strobe. Strobes on other channels, or comparator changes without a strobe, leave it unchanged. Turn-on and turn-off strobes in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rise_stb | input | NCH | Per-channel turn-on edge pulse |
| fall_stb | input | NCH | Per-channel turn-off edge pulse |
| fly_cmp | input | NCH | Flyback comparator level, 1 = below threshold |
| off_cmp | input | NCH | Off-state comparator level, 1 = above threshold |
| cur_ok | input | NCH | Current comparator level, 1 = below limit |
| therm_ok | input | 1 | Thermal flag, 0 = overtemperature |
| rst_pin_a | input | 1 | Level of first external reset pin |
| rst_pin_b | input | 1 | Level of second external reset pin |
| frame_start | input | 1 | Request to snapshot a status word |
| snap_valid | output | 1 | Offered word is valid |
| snap_ready | input | 1 | Consumer accepts the offered word |
| snap_word | output | 3*NCH+4 | Packed status word |

## Verification
The bench builds the block with its default of four channels. This gives the 16-bit word with the framing bit at 15, so every field position in R4 and R5 is checked against a literal expected value. A chain of vectors carries stored flags from one frame into the next, which exposes holds and cross-channel leakage. Directed steps cover a strobe during a stalled transfer, a start that coincides with acceptance, and a mid-run reset.

// File: rtl/edge_diag_pkg.sv
package edge_diag_pkg;
  function automatic int status_width(input int nch);
    return 3 * nch + 4;
  endfunction
endpackage

// File: rtl/edge_diag_chan.sv
module edge_diag_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_stb,
  input  logic fall_stb,
  input  logic fly_cmp,
  input  logic off_cmp,
  input  logic cur_ok,
  output logic on_flag,
  output logic off_flag,
  output logic cur_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_flag  <= 1'b0;
      off_flag <= 1'b0;
      cur_flag <= 1'b1;
    end else begin
      if (rise_stb) on_flag <= fly_cmp;
      if (fall_stb) begin
        off_flag <= off_cmp;
        cur_flag <= cur_ok;
      end
    end
  end

  AST_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_stb |=> $stable(on_flag)); // R10
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> $stable(off_flag)); // R2
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> $stable(cur_flag)); // R3
endmodule

// File: rtl/edge_diag_pack.sv
module edge_diag_pack #(
  parameter int NCH = 4,
  localparam int W = edge_diag_pkg::status_width(NCH)
) (
  input  logic [NCH-1:0] on_flags,
  input  logic [NCH-1:0] off_flags,
  input  logic [NCH-1:0] cur_flags,
  input  logic           therm_ok,
  input  logic           pin_a,
  input  logic           pin_b,
  output logic [W-1:0]   word
);
  localparam int PIN_A_BIT = 2 * NCH;
  localparam int PIN_B_BIT = 2 * NCH + 1;
  localparam int THERM_BIT = 2 * NCH + 2;
  localparam int CUR_BASE  = 2 * NCH + 3;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign word[2*c]        = on_flags[c];
    assign word[2*c+1]      = off_flags[c];
    assign word[CUR_BASE+c] = cur_flags[c];
  end
  assign word[PIN_A_BIT] = pin_a;
  assign word[PIN_B_BIT] = pin_b;
  assign word[THERM_BIT] = therm_ok;
  assign word[W-1]       = 1'b1;
endmodule

// File: rtl/edge_diag_snap.sv
module edge_diag_snap #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] live_word,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] word
);
  logic take;
  assign take = start && (!valid || ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      word  <= live_word;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(word)); // R8
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start && (!valid || ready) |=> valid); // R7
  AST_DROP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !start |=> !valid); // R8
endmodule

// File: rtl/edge_diag_capture.sv
module edge_diag_capture #(
  parameter int NCH = 4,
  localparam int W = edge_diag_pkg::status_width(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rise_stb,
  input  logic [NCH-1:0] fall_stb,
  input  logic [NCH-1:0] fly_cmp,
  input  logic [NCH-1:0] off_cmp,
  input  logic [NCH-1:0] cur_ok,
  input  logic           therm_ok,
  input  logic           rst_pin_a,
  input  logic           rst_pin_b,
  input  logic           frame_start,
  output logic           snap_valid,
  input  logic           snap_ready,
  output logic [W-1:0]   snap_word
);
  logic [NCH-1:0] on_flags, off_flags, cur_flags;
  logic [W-1:0]   live_word;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    edge_diag_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_stb (rise_stb[c]),
      .fall_stb (fall_stb[c]),
      .fly_cmp  (fly_cmp[c]),
      .off_cmp  (off_cmp[c]),
      .cur_ok   (cur_ok[c]),
      .on_flag  (on_flags[c]),
      .off_flag (off_flags[c]),
      .cur_flag (cur_flags[c])
    );
  end

  edge_diag_pack #(.NCH(NCH)) u_pack (
    .on_flags  (on_flags),
    .off_flags (off_flags),
    .cur_flags (cur_flags),
    .therm_ok  (therm_ok),
    .pin_a     (rst_pin_a),
    .pin_b     (rst_pin_b),
    .word      (live_word)
  );

  edge_diag_snap #(.W(W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_start),
    .live_word (live_word),
    .valid     (snap_valid),
    .ready     (snap_ready),
    .word      (snap_word)
  );

  AST_FRAME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> snap_word[W-1]); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !snap_valid); // R9
endmodule

// File: tb/edge_diag_capture_tb_top.sv
module edge_diag_capture_tb_top;
  localparam int NCH = 4;
  localparam int W = 16;
  localparam int NV = 6;
  // {rise, fall, fly, off, cur, therm, pin_b, pin_a, expected word}
  localparam logic [38:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'b00, 16'hFC00},
    {4'b0001, 4'b0010, 4'b0001, 4'b0010, 4'b0000, 1'b1, 2'b01, 16'hED09},
    {4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 1'b0, 2'b10, 16'hEA08},
    {4'b1000, 4'b1100, 4'b1000, 4'b0100, 4'b1000, 1'b1, 2'b11, 16'hCF68},
    {4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 1'b1, 2'b00, 16'hFC40},
    {4'b0110, 4'b0110, 4'b0110, 4'b0110, 4'b0110, 1'b0, 2'b00, 16'hF87C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] rise_stb = '0, fall_stb = '0, fly_cmp = '0, off_cmp = '0, cur_ok = '1;
  logic therm_ok = 1'b1, rst_pin_a = 1'b0, rst_pin_b = 1'b0;
  logic frame_start = 1'b0, snap_ready = 1'b0;
  logic snap_valid;
  logic [W-1:0] snap_word;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_diag_capture #(.NCH(NCH)) dut_i (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic frame_and_check(input string req, input logic [W-1:0] exp);
    frame_start = 1'b1; snap_ready = 1'b0;
    step();
    frame_start = 1'b0;
    check({req, " valid"}, W'(snap_valid), W'(1));
    check(req, snap_word, exp);
    snap_ready = 1'b1;
    step();
    snap_ready = 1'b0;
    check({req, " drop R8"}, W'(snap_valid), W'(0));
  endtask

  initial begin
    step(); step();
    check("R9 reset valid", W'(snap_valid), W'(0));
    rst_n = 1'b1;
    step();
    // table walk: R1 R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      {rise_stb, fall_stb, fly_cmp, off_cmp, cur_ok, therm_ok, rst_pin_b, rst_pin_a} = VEC[i][38:16];
      step();
      rise_stb = '0; fall_stb = '0;
      fly_cmp = ~fly_cmp; off_cmp = ~off_cmp; cur_ok = ~cur_ok; // R10 no strobe, no change
      frame_and_check($sformatf("R4/R5 vec%0d", i), VEC[i][15:0]);
    end
    // R7 freeze during stalled transfer
    therm_ok = 1'b1; rst_pin_a = 1'b0; rst_pin_b = 1'b0;
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
    rise_stb = '1; fly_cmp = '0;
    step();
    rise_stb = '0; frame_start = 1'b1; // ignored while pending (R8)
    step();
    frame_start = 1'b0;
    check("R7 frozen word", snap_word, 16'hFC7C);
    check("R8 held valid", W'(snap_valid), W'(1));
    frame_start = 1'b1; snap_ready = 1'b1;
    step();
    frame_start = 1'b0; snap_ready = 1'b0;
    check("R8 accept+start valid", W'(snap_valid), W'(1));
    check("R8 accept+start word", snap_word, 16'hFC28);
    snap_ready = 1'b1;
    step();
    snap_ready = 1'b0;
    check("R8 drained", W'(snap_valid), W'(0));
    // R9 mid-run reset
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    check("R9 reset clears valid", W'(snap_valid), W'(0));
    frame_and_check("R9 cleared flags", 16'hFC00);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule